// File: doc/BRIEF.md
# Programmable Watchdog Timer With Reset Output

This block is a watchdog timer that software programs through a small set of byte-wide registers. It counts down a programmed value in units of seconds or minutes. Each unit is built from a one-millisecond tick enable that arrives from outside the block. Software keeps the system alive by writing the time register again before the count runs out. That write reloads the count and restarts the countdown.

When the count reaches zero, the block drives an active-low reset line. The line can be held low as a level, or it can be driven low as a pulse whose width is chosen by a two-bit code. An output gate decides whether the reset actually reaches the pin. A timeout status flag records every expiry. The block's own power-on reset is separate from the reset line it drives, so the flag survives the system reset that the timer causes. Software clears the flag by writing a one to it.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, every register reads 0x00 and `wdRstN` is high.
- R2: A write to index 0xF6 loads the 8-bit count and restarts the unit prescaler from zero. Reading 0xF6 returns the remaining count, which drops by one for each elapsed unit.
- R3: When config (0xF5) bit 3 is 0, one unit is `TICKS_PER_SEC` cycles on which `tickMs` is high. When bit 3 is 1, one unit is `TICKS_PER_SEC*SECS_PER_MIN` such cycles. Cycles without a tick do not count. Expiry occurs on the tick that takes a loaded count N to zero, which is the N·unit-th tick after the load.
- R4: The count moves only while config bit 5 and enable register (0x30) bit 0 are both 1. Otherwise it holds its value. A write that clears either bit releases any active reset on the next cycle.
- R5: A count of zero never causes an expiry.
- R6: In level mode (config bit 4 = 0), `wdRstN` goes low in the cycle after expiry. It stays low until a write to 0xF6 or until the timer is disabled, and it is released in the cycle after that write.
- R7: In pulse mode (config bit 4 = 1), `wdRstN` is low for W ticks after expiry. W is chosen by config bits 1:0: code 0 gives `PULSE_MS0` (1), code 1 gives `PULSE_MS1` (25), code 2 gives `PULSE_MS2` (125) and code 3 gives `PULSE_MS3` (5000).
- R8: Config bit 6 is set on expiry. Writing 1 to it clears it, and writing 0 leaves it unchanged. If both happen in the same cycle, the set wins. Nothing else clears the bit except power-on reset.
- R9: Output-config (0xF0) bit 7 gates the reset onto `wdRstN`. While the bit is 0, `wdRstN` stays high, but expiry and the status flag still take effect. Setting the bit while a level reset is active drives `wdRstN` low on the next cycle.
- R10: The config register reads back as {0, status, run, pulse, minutes, 0, width[1:0]}. Register 0xF0 reads as {gate, 7'b0}. Register 0x30 reads as {7'b0, enable}. Any other index reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, synchronous |
| tickMs | input | 1 | One-millisecond tick enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register index for the write or the readback |
| regWrData | input | 8 | Write data |
| rdData | output | 8 | Readback of the register at `regAddr` |
| wdRstN | output | 1 | Watchdog reset output, active low |

## Verification
The countdown is run in both time bases, with the unit shortened by parameters. This shows that the minutes bit multiplies the unit length instead of being ignored. Level expiries are ended in three ways: by a reload, by clearing the run bit and by clearing the enable register, which checks that each release path works. A pulse is run for each of the four width codes to separate the codes from one another. Further runs cover a masked output gate, a zero load, and a stretch with the tick held low, which tell gating, idle count and tick qualification apart from the plain countdown.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_DEV_EN  = 8'h30;
  localparam logic [7:0] ADDR_OUT_CFG = 8'hF0;
  localparam logic [7:0] ADDR_TMR_CFG = 8'hF5;
  localparam logic [7:0] ADDR_TMR_VAL = 8'hF6;

  localparam int BIT_STATUS = 6;
  localparam int BIT_RUN    = 5;
  localparam int BIT_PULSE  = 4;
  localparam int BIT_UNIT   = 3;
  localparam int BIT_GATE   = 7;

  // strobes and levels from control to the countdown datapath
  typedef struct packed {
    logic       load;
    logic [7:0] loadVal;
    logic       run;
    logic       minutes;
  } cntCtl_t;
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  cntCtl_t    ctl,
  output logic [7:0] count,
  output logic       expire
);
  localparam int MIN_TICKS = TICKS_PER_SEC * SECS_PER_MIN;
  localparam int PRE_W     = ($clog2(MIN_TICKS) < 1) ? 1 : $clog2(MIN_TICKS);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] unitLast;
  logic             active;
  logic             unitDone;

  assign unitLast = ctl.minutes ? PRE_W'(MIN_TICKS - 1) : PRE_W'(TICKS_PER_SEC - 1);
  assign active   = ctl.run && (count != 8'd0);
  assign unitDone = active && tick && (preCnt >= unitLast);
  assign expire   = unitDone && (count == 8'd1) && !ctl.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= 8'd0;
    end else if (ctl.load) begin
      count  <= ctl.loadVal;
      preCnt <= '0;
    end else if (!active) begin
      preCnt <= '0;
    end else if (tick) begin
      if (unitDone) begin
        preCnt <= '0;
        count  <= count - 8'd1;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> count == $past(ctl.loadVal)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.load) |=> count == $past(count)); // R4
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (count == 8'd0 && !ctl.load) |=> count == 8'd0); // R5
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> count == 8'd0); // R3
endmodule

// File: rtl/wdt_regs_ctl.sv
module wdt_regs_ctl
  import wdt_pkg::*;
#(
  parameter int PULSE_MS0 = 1,
  parameter int PULSE_MS1 = 25,
  parameter int PULSE_MS2 = 125,
  parameter int PULSE_MS3 = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic [7:0] count,
  input  logic       expire,
  output cntCtl_t    ctl,
  output logic [7:0] rdData,
  output logic       wdRstN
);
  localparam int PW_A   = (PULSE_MS0 > PULSE_MS1) ? PULSE_MS0 : PULSE_MS1;
  localparam int PW_B   = (PULSE_MS2 > PULSE_MS3) ? PULSE_MS2 : PULSE_MS3;
  localparam int PW_MAX = (PW_A > PW_B) ? PW_A : PW_B;
  localparam int PW_W   = $clog2(PW_MAX + 1);

  logic            devEn, outGate, runEn, pulseMode, minutes, status;
  logic [1:0]      widthSel;
  logic            rstActive, pulseOn;
  logic [PW_W-1:0] pulseLeft;
  logic            wrDev, wrGate, wrCfg, wrTime, relEvt;

  function automatic logic [PW_W-1:0] widthTicks(input logic [1:0] code);
    case (code)
      2'd0:    return PW_W'(PULSE_MS0);
      2'd1:    return PW_W'(PULSE_MS1);
      2'd2:    return PW_W'(PULSE_MS2);
      default: return PW_W'(PULSE_MS3);
    endcase
  endfunction

  assign wrDev  = regWrEn && (regAddr == ADDR_DEV_EN);
  assign wrGate = regWrEn && (regAddr == ADDR_OUT_CFG);
  assign wrCfg  = regWrEn && (regAddr == ADDR_TMR_CFG);
  assign wrTime = regWrEn && (regAddr == ADDR_TMR_VAL);

  assign relEvt = wrTime || (wrDev && !regWrData[0]) ||
                  (wrCfg && !regWrData[BIT_RUN]) || !(devEn && runEn);

  assign ctl.load    = wrTime;
  assign ctl.loadVal = regWrData;
  assign ctl.run     = devEn && runEn;
  assign ctl.minutes = minutes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devEn     <= 1'b0;
      outGate   <= 1'b0;
      runEn     <= 1'b0;
      pulseMode <= 1'b0;
      minutes   <= 1'b0;
      widthSel  <= 2'd0;
    end else begin
      if (wrDev)  devEn   <= regWrData[0];
      if (wrGate) outGate <= regWrData[BIT_GATE];
      if (wrCfg) begin
        runEn     <= regWrData[BIT_RUN];
        pulseMode <= regWrData[BIT_PULSE];
        minutes   <= regWrData[BIT_UNIT];
        widthSel  <= regWrData[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= 1'b0;
    end else if (expire) begin
      status <= 1'b1;
    end else if (wrCfg && regWrData[BIT_STATUS]) begin
      status <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstActive <= 1'b0;
      pulseOn   <= 1'b0;
      pulseLeft <= '0;
    end else if (relEvt) begin
      rstActive <= 1'b0;
      pulseOn   <= 1'b0;
      pulseLeft <= '0;
    end else if (expire) begin
      rstActive <= 1'b1;
      pulseOn   <= pulseMode;
      pulseLeft <= pulseMode ? widthTicks(widthSel) : '0;
    end else if (rstActive && pulseOn && tick) begin
      if (pulseLeft <= PW_W'(1)) begin
        rstActive <= 1'b0;
        pulseOn   <= 1'b0;
        pulseLeft <= '0;
      end else begin
        pulseLeft <= pulseLeft - PW_W'(1);
      end
    end
  end

  assign wdRstN = !(rstActive && outGate);

  always_comb begin
    case (regAddr)
      ADDR_DEV_EN:  rdData = {7'b0, devEn};
      ADDR_OUT_CFG: rdData = {outGate, 7'b0};
      ADDR_TMR_CFG: rdData = {1'b0, status, runEn, pulseMode, minutes, 1'b0, widthSel};
      ADDR_TMR_VAL: rdData = count;
      default:      rdData = 8'h00;
    endcase
  end

  AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> status); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (status && !(wrCfg && regWrData[BIT_STATUS])) |=> status); // R8
  AST_RELOAD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    wrTime |=> wdRstN); // R6
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (wrCfg && !regWrData[BIT_RUN]) |=> wdRstN); // R4
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60,
  parameter int PULSE_MS0     = 1,
  parameter int PULSE_MS1     = 25,
  parameter int PULSE_MS2     = 125,
  parameter int PULSE_MS3     = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickMs,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] rdData,
  output logic       wdRstN
);
  cntCtl_t    ctl;
  logic [7:0] count;
  logic       expire;

  wdt_regs_ctl #(
    .PULSE_MS0(PULSE_MS0), .PULSE_MS1(PULSE_MS1),
    .PULSE_MS2(PULSE_MS2), .PULSE_MS3(PULSE_MS3)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tickMs),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .count(count), .expire(expire),
    .ctl(ctl), .rdData(rdData), .wdRstN(wdRstN)
  );

  wdt_countdown #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)
  ) u_cnt (
    .clk(clk), .rstN(rstN), .tick(tickMs),
    .ctl(ctl), .count(count), .expire(expire)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam int PW0 = 1, PW1 = 2, PW2 = 3, PW3 = 6;
  localparam logic [7:0] A_EN = 8'h30, A_GATE = 8'hF0, A_CFG = 8'hF5, A_TIME = 8'hF6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickMs = 1'b1;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] rdData;
  logic       wdRstN;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int    at;
    logic  lvl;
    string tag;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t head;

  wdog_timer #(
    .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
    .PULSE_MS0(PW0), .PULSE_MS1(PW1), .PULSE_MS2(PW2), .PULSE_MS3(PW3)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .rdData(rdData), .wdRstN(wdRstN)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected reset-line levels at their cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      head = expQ.pop_front();
      total++;
      if (head.at < cyc) begin
        bad++;
        $display("FAIL %s missed cycle act=%0d exp=%0d", head.tag, cyc, head.at);
      end else if (wdRstN !== head.lvl) begin
        bad++;
        $display("FAIL %s wdRstN act=%b exp=%b cyc=%0d", head.tag, wdRstN, head.lvl, cyc);
      end
    end
  end

  function automatic int pwOf(input int code);
    case (code)
      0: return PW0;
      1: return PW1;
      2: return PW2;
      default: return PW3;
    endcase
  endfunction

  task automatic push(input int at, input logic lvl, input string tag);
    expItem_t it;
    it.at = at; it.lvl = lvl; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int ew);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; ew = cyc + 1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    summary();
    $finish;
  end

  initial begin
    int ew;
    int w;
    repeat (3) @(negedge clk);
    chk("R1 reset line", {7'b0, wdRstN}, 8'h01);
    rd(A_CFG, 8'h00, "R1 cfg");
    rd(A_TIME, 8'h00, "R1 time");
    rd(A_EN, 8'h00, "R1 enable");
    rd(A_GATE, 8'h00, "R1 gate");
    rd(8'h55, 8'h00, "R10 unmapped");
    rstN = 1'b1;
    @(negedge clk);
    wr(A_EN, 8'h01, ew);
    wr(A_GATE, 8'h80, ew);
    rd(A_EN, 8'h01, "R10 enable readback");

    // level mode, seconds
    wr(A_CFG, 8'h20, ew);
    wr(A_TIME, 8'd2, ew);
    push(ew + 7, 1'b1, "R3 before expiry sec");
    push(ew + 8, 1'b0, "R3 expiry sec");
    push(ew + 12, 1'b0, "R6 level held");
    drain();
    rd(A_CFG, 8'h60, "R8 status set");
    rd(A_TIME, 8'h00, "R2 count zero");

    // reload releases, remaining count readback
    wr(A_TIME, 8'd3, ew);
    push(ew + 1, 1'b1, "R6 reload release");
    waitTo(ew + 5);
    rd(A_TIME, 8'd2, "R2 remaining count");
    push(ew + 11, 1'b1, "R2 before expiry 2");
    push(ew + 12, 1'b0, "R2 expiry 2");
    drain();
    wr(A_CFG, 8'h00, ew);
    push(ew + 1, 1'b1, "R6 disable release");
    drain();
    rd(A_CFG, 8'h40, "R8 write 0 keeps status");
    wr(A_CFG, 8'h40, ew);
    rd(A_CFG, 8'h00, "R8 write 1 clears status");

    // minutes
    wr(A_CFG, 8'h28, ew);
    wr(A_TIME, 8'd1, ew);
    push(ew + 11, 1'b1, "R3 before expiry min");
    push(ew + 12, 1'b0, "R3 expiry min");
    drain();
    rd(A_CFG, 8'h68, "R10 cfg layout");

    // pulse widths
    for (int c = 0; c < 4; c++) begin
      wr(A_CFG, 8'h30 | 8'(c), ew);
      wr(A_TIME, 8'd1, ew);
      w = pwOf(c);
      push(ew + 3, 1'b1, "R7 before pulse");
      push(ew + 4, 1'b0, "R7 pulse start");
      if (w > 1) push(ew + 3 + w, 1'b0, "R7 pulse last");
      push(ew + 4 + w, 1'b1, "R7 pulse end");
      drain();
    end
    rd(A_CFG, 8'h73, "R7 R10 pulse cfg readback");

    // output gate
    wr(A_GATE, 8'h00, ew);
    rd(A_GATE, 8'h00, "R10 gate readback");
    wr(A_CFG, 8'h60, ew);
    rd(A_CFG, 8'h20, "R8 clear again");
    wr(A_TIME, 8'd1, ew);
    push(ew + 4, 1'b1, "R9 gated at expiry");
    push(ew + 8, 1'b1, "R9 gated later");
    drain();
    rd(A_CFG, 8'h60, "R9 status despite gate");
    wr(A_GATE, 8'h80, ew);
    push(ew + 1, 1'b0, "R9 gate drives active level");
    drain();

    // device enable
    wr(A_EN, 8'h00, ew);
    push(ew + 1, 1'b1, "R4 device off release");
    drain();
    wr(A_TIME, 8'd1, ew);
    push(ew + 8, 1'b1, "R4 no expiry while off");
    drain();
    rd(A_TIME, 8'd1, "R4 count held");
    wr(A_EN, 8'h01, ew);
    push(ew + 3, 1'b1, "R4 resume before");
    push(ew + 4, 1'b0, "R4 resume expiry");
    drain();

    // zero count
    wr(A_TIME, 8'd0, ew);
    push(ew + 1, 1'b1, "R5 reload zero release");
    push(ew + 20, 1'b1, "R5 zero never fires");
    drain();
    rd(A_TIME, 8'd0, "R5 count stays zero");

    // tick qualification
    @(negedge clk);
    tickMs = 1'b0;
    wr(A_TIME, 8'd1, ew);
    waitTo(ew + 10);
    chk("R3 no tick no expiry", {7'b0, wdRstN}, 8'h01);
    rd(A_TIME, 8'd1, "R3 no tick count held");
    tickMs = 1'b1;
    push(ew + 13, 1'b1, "R3 tick resume before");
    push(ew + 14, 1'b0, "R3 tick resume expiry");
    drain();

    summary();
    $finish;
  end
endmodule